// File: doc/BRIEF.md
# Machine-Cycle Reset Qualifier

This block decides when a controller core enters and leaves its internal reset. It runs the core's machine-cycle timing: twelve oscillator clocks per machine cycle, counted as six states of two phases each. It looks at the external reset pin only once per machine cycle, in the second phase of the fifth state. The pin arrives active high and has already been cleaned by an input hysteresis stage.

Internal reset asserts only when two sample points in a row see the pin high, which takes a pin pulse of about two machine cycles (24 oscillator clocks). A pulse that covers one sample point, or that falls between sample points, does nothing. The internal reset stays asserted while the samples stay high. It drops at the first sample that reads low. In that same clock the block raises a one-clock load strobe together with the program counter value 0000H, so execution restarts at address zero. A synchronous active-high power-on clear starts the state/phase counter from a known point.

Top module: `rst_cycle_sampler`

## Requirements
- R1: Power-on clear sets the slot to S1P1 (state index 0, phase 0), internal reset low and load strobe low. After clear, each clock advances the slot by one phase, in the order S1P1, S1P2, S2P1 … S6P2, then back to S1P1. State index k stands for S(k+1) and phase 0/1 for P1/P2.
- R2: The pin is read only on the clock edge that ends slot S5P2 (state index 4, phase 1). A high level that covers no such edge has no effect on internal reset.
- R3: A single high sample, followed by a low sample, never asserts internal reset. High samples that are not adjacent do not add up.
- R4: Internal reset goes high on the clock edge of the second consecutive high sample, and never at any other edge.
- R5: Once asserted, internal reset stays high for as long as each further sample reads high.
- R6: Internal reset goes low on the clock edge of the first low sample, and never at any other edge.
- R7: The program-counter load strobe is high for exactly one clock, in the clock where internal reset has just dropped. The program-counter value presented with it is 0000H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| por_i | input | 1 | Synchronous active-high power-on clear |
| rst_pin_i | input | 1 | Conditioned external reset level, active high |
| rst_int_o | output | 1 | Qualified internal reset |
| pc_val_o | output | 16 | Program-counter load value (restart vector) |
| pc_ld_o | output | 1 | One-clock program-counter load strobe |
| state_o | output | 3 | Current state index, 0..5 for S1..S6 |
| phase_o | output | 1 | Current phase, 0 for P1 and 1 for P2 |

## Verification
Each stimulus is aligned to the start of a machine cycle: the bench waits for S1P1 and numbers the following edges from 0. Sample edges therefore fall at 9, 21, 33 and so on. Internal reset is due one clock after the edge of the second high sample. Release and the load strobe are both due one clock after the edge of the first low sample. The driver turns each pin window into these edge numbers, converts them to absolute clock stamps and queues them. The monitor reads the outputs on falling edges and compares every rise, fall and load pulse it sees against the head of the queue. An event that was not queued, or a queued event that never shows up, counts as a mismatch.

// File: rtl/rst_cycle_pkg.sv
package rst_cycle_pkg;
    localparam int unsigned STATES     = 6;
    localparam int unsigned PHASES     = 2;
    localparam int unsigned CYCLE_CLKS = STATES * PHASES;
    localparam int unsigned CNT_W      = $clog2(CYCLE_CLKS);
    localparam int unsigned STATE_W    = $clog2(STATES);
    localparam int unsigned PC_W       = 16;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               phase;
    } slot_t;

    // Linear clock index of a state/phase pair, both numbered from 1.
    function automatic logic [CNT_W-1:0] slot_index(input int unsigned st_num,
                                                    input int unsigned ph_num);
        return CNT_W'((st_num - 1) * PHASES + (ph_num - 1));
    endfunction

    function automatic slot_t slot_of(input logic [CNT_W-1:0] idx);
        slot_t s;
        s.state = STATE_W'(idx / CNT_W'(PHASES));
        s.phase = 1'(idx % CNT_W'(PHASES));
        return s;
    endfunction
endpackage

// File: rtl/rst_cycle_timing.sv
module rst_cycle_timing
    import rst_cycle_pkg::*;
#(
    parameter int unsigned SMP_STATE = 5,
    parameter int unsigned SMP_PHASE = 2
) (
    input  logic  clk_i,
    input  logic  por_i,
    output slot_t slot_o,
    output logic  smp_stb_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CYCLE_CLKS - 1);
    localparam logic [CNT_W-1:0] SMP_IDX  = slot_index(SMP_STATE, SMP_PHASE);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (por_i)                cnt_q <= '0;
        else if (cnt_q == LAST_IDX) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    assign slot_o    = slot_of(cnt_q);
    assign smp_stb_o = (cnt_q == SMP_IDX);

    // R1: last slot of a machine cycle is followed by S1P1
    a_r1_cycle_wrap: assert property (@(posedge clk_i) disable iff (por_i)
        (slot_o.state == STATE_W'(STATES - 1) && slot_o.phase)
        |=> (slot_o.state == '0 && !slot_o.phase));

    // R1: phase alternates every clock
    a_r1_phase_alt: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> (slot_o.phase != $past(slot_o.phase)));
endmodule

// File: rtl/rst_cycle_qualifier.sv
module rst_cycle_qualifier #(
    parameter int unsigned ACCEPT = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic smp_stb_i,
    input  logic pin_i,
    output logic rst_int_o,
    output logic release_o
);
    localparam int unsigned HW = $clog2(ACCEPT + 1);
    localparam logic [HW-1:0] HIT_MAX  = HW'(ACCEPT);
    localparam logic [HW-1:0] HIT_NEAR = HW'(ACCEPT - 1);

    logic [HW-1:0] hits_q;
    logic          rst_q;
    logic          rel_q;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            hits_q <= '0;
            rst_q  <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            rel_q <= 1'b0;
            if (smp_stb_i) begin
                if (pin_i) begin
                    if (hits_q != HIT_MAX) hits_q <= hits_q + 1'b1;
                    if (hits_q >= HIT_NEAR) rst_q <= 1'b1;
                end else begin
                    hits_q <= '0;
                    rst_q  <= 1'b0;
                    if (rst_q) rel_q <= 1'b1;
                end
            end
        end
    end

    assign rst_int_o = rst_q;
    assign release_o = rel_q;

    // R2: internal reset only moves on a sample edge
    a_r2_quiet_between: assert property (@(posedge clk_i) disable iff (por_i)
        !smp_stb_i |=> $stable(rst_q));

    // R4: assertion needs a high sample at that edge
    a_r4_rise_on_high: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(rst_q) |-> ($past(smp_stb_i) && $past(pin_i)));

    // R5: a high sample keeps an asserted reset
    a_r5_hold_high: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_q && smp_stb_i && pin_i) |=> rst_q);

    // R6: release only on a low sample
    a_r6_fall_on_low: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(rst_q) |-> ($past(smp_stb_i) && !$past(pin_i)));
endmodule

// File: rtl/rst_cycle_sampler.sv
module rst_cycle_sampler
    import rst_cycle_pkg::*;
#(
    parameter int unsigned    SMP_STATE  = 5,
    parameter int unsigned    SMP_PHASE  = 2,
    parameter int unsigned    ACCEPT     = 2,
    parameter logic [PC_W-1:0] RESTART_PC = '0
) (
    input  logic            clk_i,
    input  logic            por_i,
    input  logic            rst_pin_i,
    output logic            rst_int_o,
    output logic [PC_W-1:0] pc_val_o,
    output logic            pc_ld_o,
    output logic [2:0]      state_o,
    output logic            phase_o
);
    slot_t slot;
    logic  smp_stb;
    logic  rel;

    rst_cycle_timing #(
        .SMP_STATE(SMP_STATE),
        .SMP_PHASE(SMP_PHASE)
    ) u_timing (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .slot_o   (slot),
        .smp_stb_o(smp_stb)
    );

    rst_cycle_qualifier #(
        .ACCEPT(ACCEPT)
    ) u_qual (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .smp_stb_i(smp_stb),
        .pin_i    (rst_pin_i),
        .rst_int_o(rst_int_o),
        .release_o(rel)
    );

    assign pc_ld_o  = rel;
    assign pc_val_o = RESTART_PC;
    assign state_o  = 3'(slot.state);
    assign phase_o  = slot.phase;

    // R7: load strobe lasts one clock
    a_r7_load_single: assert property (@(posedge clk_i) disable iff (por_i)
        pc_ld_o |=> !pc_ld_o);

    // R7: load strobe coincides with reset just dropped
    a_r7_load_on_release: assert property (@(posedge clk_i) disable iff (por_i)
        pc_ld_o |-> ($past(rst_int_o) && !rst_int_o));
endmodule

// File: tb/rst_cycle_sampler_tb.sv
`timescale 1ns/1ps
module rst_cycle_sampler_tb;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        pin = 1'b0;
    logic        rst_int;
    logic [15:0] pc_val;
    logic        pc_ld;
    logic [2:0]  state;
    logic        phase;

    always #10 clk = ~clk;

    rst_cycle_sampler u_dut (
        .clk_i    (clk),
        .por_i    (por),
        .rst_pin_i(pin),
        .rst_int_o(rst_int),
        .pc_val_o (pc_val),
        .pc_ld_o  (pc_ld),
        .state_o  (state),
        .phase_o  (phase)
    );

    typedef struct {
        int          kind;   // 1 rise, 2 fall, 3 load
        int unsigned at;
    } ev_t;

    ev_t         exp_q[$];
    int unsigned cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          mon_on = 1'b0;
    bit          prev_rst = 1'b0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(int kind);
        if (kind == 1) return "R4";
        if (kind == 2) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic got(input int kind);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R3 or R5: actual unexpected event kind %0d at %0d, expected none",
                     kind, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                n_bad++;
                $display("FAIL %s: actual kind %0d at %0d, expected kind %0d at %0d",
                         req_of(e.kind), kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // monitor: events compared against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (rst_int && !prev_rst) got(1);
            if (!rst_int && prev_rst) got(2);
            if (pc_ld) begin
                got(3);
                check("R7 pc value", int'(pc_val), 0);
            end
            prev_rst = rst_int;
        end
    end

    // driver: high window on edges [s, s+L) after alignment to S1P1
    task automatic apply(input int s, input int len);
        int unsigned t0;
        int k0;
        int n;
        ev_t e;
        @(negedge clk);
        while (!(state == 3'd0 && phase == 1'b0)) @(negedge clk);
        t0 = cyc;
        k0 = -1;
        n  = 0;
        for (int k = 0; k < 40; k++) begin
            if (9 + 12 * k >= s && 9 + 12 * k < s + len) begin
                if (k0 < 0) k0 = k;
                n++;
            end
        end
        if (n >= 2) begin
            e.kind = 1; e.at = t0 + 9 + 12 * (k0 + 1) + 1; exp_q.push_back(e);
            e.kind = 2; e.at = t0 + 9 + 12 * (k0 + n) + 1; exp_q.push_back(e);
            e.kind = 3; exp_q.push_back(e);
        end
        if (s == 0) pin = 1'b1;
        else begin
            repeat (s) @(negedge clk);
            pin = 1'b1;
        end
        repeat (len) @(negedge clk);
        pin = 1'b0;
        repeat (30) @(negedge clk);
        // R2 R3 R6: idle after the window
        check("R6 idle after window", int'(rst_int), 0);
        check("R7 idle strobe", int'(pc_ld), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rst_int", int'(rst_int), 0);
        check("R1 pc_ld", int'(pc_ld), 0);
        check("R1 state", int'(state), 0);
        check("R1 phase", int'(phase), 0);
        por = 1'b0;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            check("R1 state seq", int'(state), (k % 12) / 2);
            check("R1 phase seq", int'(phase), k % 2);
        end
        prev_rst = rst_int;
        mon_on = 1'b1;

        apply(0, 9);    // R2: ends before first sample
        apply(10, 11);  // R2: fits between samples
        apply(0, 10);   // R3: one sample only
        apply(0, 12);   // R3: one sample only
        apply(10, 23);  // R3: 23 clocks, one sample
        apply(0, 10);   // R3: isolated highs in separate cycles
        apply(0, 10);
        apply(0, 22);   // R4: just two samples
        apply(0, 24);   // R4: exactly two machine cycles
        apply(22, 24);  // R4: window not aligned to cycle start
        apply(0, 60);   // R5 R6 R7: long hold, five samples
        apply(5, 100);  // R5: longer hold

        mon_on = 1'b0;
        while (exp_q.size() > 0) begin
            ev_t e;
            e = exp_q.pop_front();
            n_cmp++;
            n_bad++;
            $display("FAIL %s: actual missing, expected kind %0d at %0d",
                     req_of(e.kind), e.kind, e.at);
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule